// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small, fully associative translation cache for 4 KiB pages. Each cached translation is marked with a 12-bit address-space tag. Translations that belong to several address spaces can therefore stay resident together, and switching between spaces does not throw them away. The block keeps private copies of two control registers. One is a page-table base register; its low 12 bits name the active address space. The other is a mode register; bit 17 of it switches tagging on.

A privileged write port updates the two copies, and only a caller at privilege level 0 may change them. A combinational lookup port returns a hit flag and a physical page number. It can hit only on entries tagged with the active address-space tag. After an external table walk, a refill port installs a new translation under the active tag. Reloading the page-table base keeps the cache contents when tagging is on. When tagging is off, the same reload empties the whole cache.

Top module: `ctx_tlb`

## Requirements
- R1: After reset, no lookup hits, `cur_ctx` is 0 and `tag_en` is 0. Both register copies read as zero and every entry is invalid.
- R2: A register write takes effect only when `priv_lvl` is 0. At any other privilege level the write changes neither register and causes no invalidation.
- R3: `tag_en` follows bit 17 of the mode register (`reg_wr_sel` = 1). While it is 0, `cur_ctx` is 12'h000 whatever the base register holds.
- R4: While `tag_en` is 1, `cur_ctx` equals bits 11:0 of the page-table base register (`reg_wr_sel` = 0).
- R5: A lookup is combinational and answers in the same cycle as its request. It hits only on a valid entry whose stored tag equals `cur_ctx` and whose virtual page number equals `lkp_vpn`. On a hit, `lkp_ppn` carries the stored physical page number.
- R6: With tagging on, an accepted base-register write leaves every cached entry valid. Entries of other tags become visible again when their tag becomes current.
- R7: With tagging off, an accepted base-register write invalidates every entry on the next clock edge. A refill presented in that same cycle is dropped.
- R8: A refill takes effect on the next edge and stores the entry under the current `cur_ctx`. It fills the lowest-numbered invalid entry when one exists.
- R9: When all entries are valid, a refill replaces the entry named by a rotating pointer. The pointer starts at entry 0 after reset and advances by one after each such replacement.
- R10: A refill whose virtual page number already hits under the current tag overwrites that entry in place. It neither consumes a free entry nor moves the rotating pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_lvl | input | 2 | Privilege level of the register writer; 0 is the only one allowed |
| reg_wr_en | input | 1 | Register write request |
| reg_wr_sel | input | 1 | 0 = page-table base register, 1 = mode register |
| reg_wr_data | input | 32 | Value to write |
| lkp_vpn | input | 20 | Virtual page number to translate |
| lkp_hit | output | 1 | Lookup found a matching entry |
| lkp_ppn | output | 20 | Physical page number of the matching entry, 0 on a miss |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_ppn | input | 20 | Physical page number being installed |
| cur_ctx | output | 12 | Active address-space tag |
| tag_en | output | 1 | Tagging enabled |

## Verification
The bench switches between two tags and back again. A design that flushed on every base reload, or that ignored the tag when comparing, would then lose the first translation or return the wrong physical page. It reloads the base with tagging off, including a reload in the same cycle as a refill, and a design that kept stale entries would still hit afterwards. Base and mode writes at privilege levels 2 and 3 must leave both the tag and the contents untouched. The bench fills all eight entries and then forces rotating replacement and an in-place overwrite. A design with the wrong pointer start, or one that let an overwrite move the pointer, would evict the wrong page.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    localparam int unsigned XLEN        = 32;
    localparam int unsigned CTX_W       = 12;
    localparam int unsigned VPN_W       = 20;
    localparam int unsigned PPN_W       = 20;
    localparam int unsigned TLB_ENTRIES = 8;
    localparam int unsigned TAG_EN_BIT  = 17;
    localparam int unsigned IDX_W       = $clog2(TLB_ENTRIES);

    typedef logic [CTX_W-1:0] ctx_t;
    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [XLEN-1:0]  xword_t;

    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_MODE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic valid;
        ctx_t ctx;
        vpn_t vpn;
        ppn_t ppn;
    } tlb_entry_t;

    // Active tag: base-register low field when tagging is on, zero otherwise
    function automatic ctx_t derive_ctx(xword_t base, xword_t mode);
        return mode[TAG_EN_BIT] ? base[CTX_W-1:0] : '0;
    endfunction

endpackage

// File: rtl/ctx_ctrl_regs.sv
module ctx_ctrl_regs
    import ctx_tlb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   priv_lvl,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [XLEN-1:0] wr_data,
    output ctx_t         cur_ctx,
    output logic         tag_en,
    output logic         flush_all
);

    xword_t   base_q;
    xword_t   mode_q;
    logic     wr_ok;
    logic     base_wr;
    logic     mode_wr;
    reg_sel_e sel;

    assign sel     = reg_sel_e'(wr_sel);
    assign wr_ok   = wr_en && (priv_lvl == 2'd0);
    assign base_wr = wr_ok && (sel == SEL_BASE);
    assign mode_wr = wr_ok && (sel == SEL_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            mode_q <= '0;
        end else begin
            if (base_wr) base_q <= wr_data;
            if (mode_wr) mode_q <= wr_data;
        end
    end

    assign tag_en    = mode_q[TAG_EN_BIT];
    assign cur_ctx   = derive_ctx(base_q, mode_q);
    // Untagged operation: a base reload must drop every cached translation
    assign flush_all = base_wr && !tag_en;

    logic shadow_unused;
    assign shadow_unused = ^{base_q[XLEN-1:CTX_W], mode_q[XLEN-1:TAG_EN_BIT+1],
                             mode_q[TAG_EN_BIT-1:0]};

    AST_LOW_PRIV_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && priv_lvl != 2'd0) |=> ($stable(base_q) && $stable(mode_q))); // R2

    AST_CTX_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !wr_data[TAG_EN_BIT]) |=> (cur_ctx == '0)); // R3

    AST_CTX_FROM_BASE: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && wr_data[TAG_EN_BIT] && !base_wr)
            |=> (cur_ctx == $past(base_q[CTX_W-1:0]))); // R4

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim
    import ctx_tlb_pkg::*;
#(
    parameter int unsigned N = TLB_ENTRIES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] valid_vec,
    input  logic [N-1:0] dup_vec,
    input  logic         fill_go,
    output idx_t         wr_idx
);

    idx_t rr_ptr;
    idx_t free_idx;
    idx_t dup_idx;
    logic have_free;
    logic have_dup;
    logic use_rr;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        have_dup  = 1'b0;
        dup_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = idx_t'(i);
            end
            if (dup_vec[i]) begin
                have_dup = 1'b1;
                dup_idx  = idx_t'(i);
            end
        end
    end

    assign use_rr = !have_dup && !have_free;
    assign wr_idx = have_dup ? dup_idx : (have_free ? free_idx : rr_ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (fill_go && use_rr) begin
            rr_ptr <= (rr_ptr == idx_t'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    AST_DUP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dup_vec)); // R10

    AST_RR_STEPS: assert property (@(posedge clk) disable iff (rst)
        (fill_go && use_rr) |=> (rr_ptr != $past(rr_ptr))); // R9

    AST_RR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fill_go && !use_rr) |=> $stable(rr_ptr)); // R10

endmodule

// File: rtl/ctx_tlb_array.sv
module ctx_tlb_array
    import ctx_tlb_pkg::*;
#(
    parameter int unsigned N = TLB_ENTRIES
) (
    input  logic clk,
    input  logic rst,
    input  ctx_t cur_ctx,
    input  vpn_t lkp_vpn,
    output logic lkp_hit,
    output ppn_t lkp_ppn,
    input  logic fill_en,
    input  vpn_t fill_vpn,
    input  ppn_t fill_ppn,
    input  logic flush_all
);

    logic [N-1:0]            valid_vec;
    logic [N-1:0]            lkp_match;
    logic [N-1:0]            dup_vec;
    logic [N-1:0][PPN_W-1:0] ppn_vec;
    logic                    fill_go;
    idx_t                    wr_idx;

    // A flush in the same cycle wins over a refill
    assign fill_go = fill_en && !flush_all;

    for (genvar g = 0; g < N; g++) begin : g_ent
        tlb_entry_t ent_q;

        assign valid_vec[g] = ent_q.valid;
        assign lkp_match[g] = ent_q.valid && (ent_q.ctx == cur_ctx) && (ent_q.vpn == lkp_vpn);
        assign dup_vec[g]   = ent_q.valid && (ent_q.ctx == cur_ctx) && (ent_q.vpn == fill_vpn);
        assign ppn_vec[g]   = lkp_match[g] ? ent_q.ppn : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (flush_all) begin
                ent_q.valid <= 1'b0;
            end else if (fill_go && (wr_idx == idx_t'(g))) begin
                ent_q <= '{valid: 1'b1, ctx: cur_ctx, vpn: fill_vpn, ppn: fill_ppn};
            end
        end
    end

    always_comb begin
        lkp_ppn = '0;
        for (int i = 0; i < N; i++) begin
            lkp_ppn = lkp_ppn | ppn_vec[i];
        end
    end
    assign lkp_hit = |lkp_match;

    ctx_tlb_victim #(.N(N)) i_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .dup_vec   (dup_vec),
        .fill_go   (fill_go),
        .wr_idx    (wr_idx)
    );

    AST_LOOKUP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lkp_match)); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_vec == '0)); // R7

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> valid_vec[$past(wr_idx)]); // R8

    AST_ENTRIES_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!fill_go && !flush_all) |=> (valid_vec == $past(valid_vec))); // R6

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       priv_lvl,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sel,
    input  logic [XLEN-1:0]  reg_wr_data,
    input  logic [VPN_W-1:0] lkp_vpn,
    output logic             lkp_hit,
    output logic [PPN_W-1:0] lkp_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    output logic [CTX_W-1:0] cur_ctx,
    output logic             tag_en
);

    logic flush_all;

    ctx_ctrl_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .priv_lvl  (priv_lvl),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .cur_ctx   (cur_ctx),
        .tag_en    (tag_en),
        .flush_all (flush_all)
    );

    ctx_tlb_array #(.N(TLB_ENTRIES)) i_array (
        .clk       (clk),
        .rst       (rst),
        .cur_ctx   (cur_ctx),
        .lkp_vpn   (lkp_vpn),
        .lkp_hit   (lkp_hit),
        .lkp_ppn   (lkp_ppn),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .flush_all (flush_all)
    );

    AST_MISS_ZERO_PPN: assert property (@(posedge clk) disable iff (rst)
        !lkp_hit |-> (lkp_ppn == '0)); // R5

endmodule

// File: tb/test_ctx_tlb.sv
module test_ctx_tlb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  priv_lvl = 2'd0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [19:0] lkp_vpn = '0;
    logic        lkp_hit;
    logic [19:0] lkp_ppn;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [11:0] cur_ctx;
    logic        tag_en;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] MODE_ON  = 32'h0002_0000;
    localparam logic [31:0] MODE_OFF = 32'h0000_0000;

    always #2 clk = ~clk;

    ctx_tlb i_ctx_tlb (
        .clk(clk), .rst(rst), .priv_lvl(priv_lvl),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .lkp_vpn(lkp_vpn), .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .cur_ctx(cur_ctx), .tag_en(tag_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] data, input logic [1:0] priv);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data; priv_lvl = priv;
        @(negedge clk);
        reg_wr_en = 1'b0; priv_lvl = 2'd0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Same-cycle answer: drive after the negedge, sample before the posedge
    task automatic look(input logic [19:0] vpn, input bit exp_hit, input logic [19:0] exp_ppn, input string req);
        lkp_vpn = vpn;
        #1;
        chk(lkp_hit == exp_hit, req, {31'd0, lkp_hit}, {31'd0, exp_hit});
        if (exp_hit) chk(lkp_ppn == exp_ppn, req, {12'd0, lkp_ppn}, {12'd0, exp_ppn});
    endtask

    task automatic test_reset();
        do_reset();
        #1;
        chk(cur_ctx == 12'h000, "R1 ctx", {20'd0, cur_ctx}, 32'd0);
        chk(tag_en == 1'b0, "R1 tag_en", {31'd0, tag_en}, 32'd0);
        look(20'h00000, 1'b0, '0, "R1 empty");
        look(20'h12345, 1'b0, '0, "R1 empty");
    endtask

    task automatic test_priv();
        do_reset();
        reg_write(1'b1, MODE_ON, 2'd3);
        #1 chk(tag_en == 1'b0, "R2 mode ignored", {31'd0, tag_en}, 32'd0);
        refill(20'h00010, 20'h00020);
        reg_write(1'b0, 32'h0000_0001, 2'd2);
        look(20'h00010, 1'b1, 20'h00020, "R2 base ignored no flush");
        chk(cur_ctx == 12'h000, "R2 ctx", {20'd0, cur_ctx}, 32'd0);
        reg_write(1'b1, MODE_ON, 2'd0);
        #1 chk(tag_en == 1'b1, "R3 tag_en on", {31'd0, tag_en}, 32'd1);
        chk(cur_ctx == 12'h001 - 12'h001, "R4 base still zero", {20'd0, cur_ctx}, 32'd0);
    endtask

    task automatic test_tagged();
        do_reset();
        reg_write(1'b1, MODE_ON, 2'd0);
        reg_write(1'b0, 32'hABCD_5123, 2'd0);
        #1 chk(cur_ctx == 12'h123, "R4 ctx from base", {20'd0, cur_ctx}, 32'h123);
        refill(20'hAAAAA, 20'h11111);
        look(20'hAAAAA, 1'b1, 20'h11111, "R8 fill visible");
        reg_write(1'b0, 32'h0000_7045, 2'd0);
        #1 chk(cur_ctx == 12'h045, "R4 ctx switch", {20'd0, cur_ctx}, 32'h045);
        look(20'hAAAAA, 1'b0, '0, "R5 other tag misses");
        refill(20'hAAAAA, 20'h22222);
        look(20'hAAAAA, 1'b1, 20'h22222, "R10 same vpn other tag");
        reg_write(1'b0, 32'h0000_5123, 2'd0);
        look(20'hAAAAA, 1'b1, 20'h11111, "R6 kept across switch");
        reg_write(1'b1, MODE_OFF, 2'd0);
        #1 chk(cur_ctx == 12'h000, "R3 ctx forced zero", {20'd0, cur_ctx}, 32'd0);
        look(20'hAAAAA, 1'b0, '0, "R5 tag 0 misses");
        refill(20'h00042, 20'h00777);
        look(20'h00042, 1'b1, 20'h00777, "R8 untagged fill");
        reg_write(1'b0, 32'h0000_9000, 2'd0);
        look(20'h00042, 1'b0, '0, "R7 flush untagged");
        reg_write(1'b1, MODE_ON, 2'd0);
        reg_write(1'b0, 32'h0000_5123, 2'd0);
        look(20'hAAAAA, 1'b0, '0, "R7 flush drops all tags");
    endtask

    task automatic test_flush_fill();
        do_reset();
        refill(20'h00300, 20'h00400);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 32'h1; priv_lvl = 2'd0;
        fill_en = 1'b1; fill_vpn = 20'h00301; fill_ppn = 20'h00401;
        @(negedge clk);
        reg_wr_en = 1'b0; fill_en = 1'b0;
        look(20'h00301, 1'b0, '0, "R7 same-cycle refill dropped");
        look(20'h00300, 1'b0, '0, "R7 old entry gone");
    endtask

    task automatic test_replace();
        do_reset();
        for (int i = 0; i < 8; i++) refill(20'h00100 + 20'(i), 20'h00200 + 20'(i));
        for (int i = 0; i < 8; i++) look(20'h00100 + 20'(i), 1'b1, 20'h00200 + 20'(i), "R8 all filled");
        refill(20'h001F0, 20'h002F0);
        look(20'h00100, 1'b0, '0, "R9 rr evicts entry 0");
        look(20'h001F0, 1'b1, 20'h002F0, "R9 new entry");
        look(20'h00101, 1'b1, 20'h00201, "R9 entry 1 kept");
        refill(20'h001F1, 20'h002F1);
        look(20'h00101, 1'b0, '0, "R9 rr evicts entry 1");
        refill(20'h00105, 20'h003AA);
        look(20'h00105, 1'b1, 20'h003AA, "R10 overwrite in place");
        look(20'h00102, 1'b1, 20'h00202, "R10 no eviction");
        refill(20'h001F2, 20'h002F2);
        look(20'h00102, 1'b0, '0, "R10 pointer not moved");
        look(20'h00103, 1'b1, 20'h00203, "R9 entry 3 kept");
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_priv();
        test_tagged();
        test_flush_fill();
        test_replace();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule